// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four Static Memory

This block is a synthesizable behavioural model of a small static memory with two data ports, one for reads and one for writes. Both ports run at double data rate and share one address bus. Time is divided into two-cycle slots. The first clock edge of a slot samples the active-low read and write strobes and carries the read address. The second edge carries the write address. Every accepted address selects an aligned group of four words. The four words move in two clock cycles, two words per cycle. The double-data-rate transfer is modelled as a pair of parallel word ports: one port for the word on the rising edge and one for the word on the falling edge.

Write data for a burst is collected over two edges. It is then held for one cycle in a pending buffer before it is committed to the array. A read that starts while that buffer still holds data for the same group takes the buffered words, lane by lane, in place of the stale array contents. A read and a write may each be in progress at the same time. When both strobes are active in the same slot, the read is accepted and the write is dropped.

Top module: `qdr4_sram`

## Requirements
- R1: While `rst_n` is low, `rd_oe`, `rd_rise` and `rd_fall` are 0. The first rising edge after release is a slot start. Reset does not alter the array contents.
- R2: Strobes are sampled only on slot-start edges: the first edge after reset and then every second edge. Strobes active on the other edge of a slot have no effect on the array or on the read port.
- R3: A read is accepted when `rd_req_n` is 0 on a slot-start edge, with `addr` at that edge as the group G. After the next edge, `rd_rise`/`rd_fall` carry words 4G and 4G+1. After the edge that follows, they carry words 4G+2 and 4G+3.
- R4: A write is accepted when `wr_req_n` is 0 and `rd_req_n` is 1 on a slot-start edge. The group is taken from `addr` on the following edge. Words 0 and 1 are taken from `wd_rise`/`wd_fall` at that edge, and words 2 and 3 at the edge after it.
- R5: When both strobes are 0 on the same slot-start edge, only the read is performed, and the array keeps its previous contents.
- R6: Each word has two active-low lane enables. Bit 0 of `wbe_rise_n`/`wbe_fall_n` guards data bits 8:0 and bit 1 guards bits 17:9. The enables are sampled with their word, and a lane whose enable is 1 is left unchanged.
- R7: A read of the group written by the write accepted in the immediately preceding slot returns the new words, merged lane by lane with the old contents, even though they have not yet reached the array.
- R8: `rd_oe` is 1 for exactly the two cycles of each read burst. It is 0 in any cycle not covered by a burst, and the data outputs are 0 while it is 0. Back-to-back read slots keep it high without a gap.
- R9: Word address = group × 4 + beat, with beat 0 to 3. A burst never wraps into a neighbouring group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_n | input | 1 | Active-low read strobe |
| wr_req_n | input | 1 | Active-low write strobe |
| addr | input | AW | Shared group address (read on slot start, write on second edge) |
| wd_rise | input | DW | Write word for the rising-edge beat |
| wd_fall | input | DW | Write word for the falling-edge beat |
| wbe_rise_n | input | LANES | Active-low lane enables for `wd_rise` |
| wbe_fall_n | input | LANES | Active-low lane enables for `wd_fall` |
| rd_rise | output | DW | Read word for the rising-edge beat |
| rd_fall | output | DW | Read word for the falling-edge beat |
| rd_oe | output | 1 | Read data valid; models the output driver enable |

## Verification
A slot phase that slipped by one edge would make a read strobe be missed or a write address be taken from the wrong cycle. Either fault shows on the read port within one slot of the next request. A lost or late pending buffer shows as stale words on the first read that follows a write to the same group, two cycles after that read is requested. Lane-merge errors show only in the masked lanes, so writes with mixed enables are read back both from the forwarding path and later from the array. The bench also predicts the exact cycle at which each word pair arrives, so a latency error of one cycle makes both the idle-port check and the data check fail.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;

  typedef enum logic {
    SLOT_START = 1'b0,
    SLOT_WADDR = 1'b1
  } slot_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qdr4_slot_ctrl.sv
module qdr4_slot_ctrl
  import qdr4_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req_n,
  input  logic          wr_req_n,
  input  logic [AW-1:0] addr,
  output logic          rd_fire,
  output logic [AW-1:0] rd_base,
  output logic          wr_first,
  output logic          wr_second,
  output logic [AW-1:0] wr_base
);
  slot_e phase_q, phase_d;
  logic  rd_acc, wr_acc;

  always_comb begin
    phase_d = (phase_q == SLOT_START) ? SLOT_WADDR : SLOT_START;
    rd_acc  = (phase_q == SLOT_START) && !rd_req_n;
    wr_acc  = (phase_q == SLOT_START) && rd_req_n && !wr_req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= SLOT_START;
      rd_fire   <= 1'b0;
      wr_first  <= 1'b0;
      wr_second <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      rd_fire   <= rd_acc;
      wr_first  <= wr_acc;
      wr_second <= wr_first;
    end
  end

  // address registers: enabled loads, no reset needed
  always_ff @(posedge clk) begin
    if (rd_acc)   rd_base <= addr;
    if (wr_first) wr_base <= addr;
  end

  // R2
  rd_on_second_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (phase_q == SLOT_WADDR));

  // R5
  no_dual_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire && wr_first));

  // R4
  wr_step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_second |-> $past(wr_first));
endmodule

// File: rtl/qdr4_wr_path.sv
module qdr4_wr_path
  import qdr4_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_first,
  input  logic                              wr_second,
  input  logic [AW-1:0]                     wr_base,
  input  logic [DW-1:0]                     wd_rise,
  input  logic [DW-1:0]                     wd_fall,
  input  logic [LANES-1:0]                  wbe_rise_n,
  input  logic [LANES-1:0]                  wbe_fall_n,
  output logic                              pend_valid,
  output logic [AW-1:0]                     pend_base,
  output logic [BEATS-1:0][DW-1:0]          pend_word,
  output logic [BEATS-1:0][LANES-1:0]       pend_en
);
  logic [1:0][DW-1:0]    col_word;
  logic [1:0][LANES-1:0] col_en;
  logic                  pend_valid_d;

  always_comb pend_valid_d = wr_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_valid <= 1'b0;
    else        pend_valid <= pend_valid_d;
  end

  // first half of the burst: beats 0 and 1
  always_ff @(posedge clk) begin
    if (wr_first) begin
      col_word[0] <= wd_rise;
      col_word[1] <= wd_fall;
      col_en[0]   <= ~wbe_rise_n;
      col_en[1]   <= ~wbe_fall_n;
    end
  end

  // second half arrives: whole burst moves into the pending buffer
  always_ff @(posedge clk) begin
    if (wr_second) begin
      pend_base    <= wr_base;
      pend_word[0] <= col_word[0];
      pend_word[1] <= col_word[1];
      pend_word[2] <= wd_rise;
      pend_word[3] <= wd_fall;
      pend_en[0]   <= col_en[0];
      pend_en[1]   <= col_en[1];
      pend_en[2]   <= ~wbe_rise_n;
      pend_en[3]   <= ~wbe_fall_n;
    end
  end

  // R7
  pend_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> !pend_valid);
endmodule

// File: rtl/qdr4_array.sv
module qdr4_array
  import qdr4_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [AW-1:0]               wr_base,
  input  logic [BEATS-1:0][DW-1:0]    wr_word,
  input  logic [BEATS-1:0][LANES-1:0] wr_en,
  input  logic [AW-1:0]               rd_base,
  output logic [BEATS-1:0][DW-1:0]    rd_word
);
  localparam int LW    = DW / LANES;
  localparam int WORDS = (1 << AW) * BEATS;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BEATS; b++) begin
        for (int l = 0; l < LANES; l++) begin
          if (wr_en[b][l])
            mem[{wr_base, BEAT_W'(b)}][l*LW +: LW] <= wr_word[b][l*LW +: LW];
        end
      end
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    assign rd_word[b] = mem[{rd_base, BEAT_W'(b)}];
  end
endmodule

// File: rtl/qdr4_rd_path.sv
module qdr4_rd_path
  import qdr4_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [AW-1:0]               rd_base,
  input  logic [BEATS-1:0][DW-1:0]    arr_word,
  input  logic                        pend_valid,
  input  logic [AW-1:0]               pend_base,
  input  logic [BEATS-1:0][DW-1:0]    pend_word,
  input  logic [BEATS-1:0][LANES-1:0] pend_en,
  output logic [DW-1:0]               rd_rise,
  output logic [DW-1:0]               rd_fall,
  output logic                        rd_oe
);
  localparam int LW = DW / LANES;

  logic                     hit;
  logic [BEATS-1:0][DW-1:0] merged;
  logic [1:0][DW-1:0]       hold_q;
  logic                     tail_q, tail_d, oe_d;
  logic [DW-1:0]            rise_d, fall_d;

  assign hit = pend_valid && (pend_base == rd_base);

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[b][l*LW +: LW] = (hit && pend_en[b][l]) ?
                                     pend_word[b][l*LW +: LW] :
                                     arr_word[b][l*LW +: LW];
    end
  end

  always_comb begin
    rise_d = '0;
    fall_d = '0;
    oe_d   = 1'b0;
    tail_d = 1'b0;
    if (fire) begin
      rise_d = merged[0];
      fall_d = merged[1];
      oe_d   = 1'b1;
      tail_d = 1'b1;
    end else if (tail_q) begin
      rise_d = hold_q[0];
      fall_d = hold_q[1];
      oe_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rise <= '0;
      rd_fall <= '0;
      rd_oe   <= 1'b0;
      tail_q  <= 1'b0;
    end else begin
      rd_rise <= rise_d;
      rd_fall <= fall_d;
      rd_oe   <= oe_d;
      tail_q  <= tail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      hold_q[0] <= merged[2];
      hold_q[1] <= merged[3];
    end
  end

  // R8
  oe_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ##1 rd_oe ##1 rd_oe);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_rise == '0 && rd_fall == '0));

  // R3
  oe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> $past(fire));
endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram
  import qdr4_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req_n,
  input  logic             wr_req_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wd_rise,
  input  logic [DW-1:0]    wd_fall,
  input  logic [LANES-1:0] wbe_rise_n,
  input  logic [LANES-1:0] wbe_fall_n,
  output logic [DW-1:0]    rd_rise,
  output logic [DW-1:0]    rd_fall,
  output logic             rd_oe
);
  logic                        rd_fire, wr_first, wr_second;
  logic [AW-1:0]               rd_base, wr_base, pend_base;
  logic                        pend_valid;
  logic [BEATS-1:0][DW-1:0]    pend_word, arr_word;
  logic [BEATS-1:0][LANES-1:0] pend_en;

  qdr4_slot_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req_n (rd_req_n),
    .wr_req_n (wr_req_n),
    .addr     (addr),
    .rd_fire  (rd_fire),
    .rd_base  (rd_base),
    .wr_first (wr_first),
    .wr_second(wr_second),
    .wr_base  (wr_base)
  );

  qdr4_wr_path #(.AW(AW), .DW(DW), .LANES(LANES)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_first  (wr_first),
    .wr_second (wr_second),
    .wr_base   (wr_base),
    .wd_rise   (wd_rise),
    .wd_fall   (wd_fall),
    .wbe_rise_n(wbe_rise_n),
    .wbe_fall_n(wbe_fall_n),
    .pend_valid(pend_valid),
    .pend_base (pend_base),
    .pend_word (pend_word),
    .pend_en   (pend_en)
  );

  qdr4_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_arr (
    .clk    (clk),
    .we     (pend_valid),
    .wr_base(pend_base),
    .wr_word(pend_word),
    .wr_en  (pend_en),
    .rd_base(rd_base),
    .rd_word(arr_word)
  );

  qdr4_rd_path #(.AW(AW), .DW(DW), .LANES(LANES)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (rd_fire),
    .rd_base   (rd_base),
    .arr_word  (arr_word),
    .pend_valid(pend_valid),
    .pend_base (pend_base),
    .pend_word (pend_word),
    .pend_en   (pend_en),
    .rd_rise   (rd_rise),
    .rd_fall   (rd_fall),
    .rd_oe     (rd_oe)
  );
endmodule

// File: tb/qdr4_sram_bench.sv
`timescale 1ns/1ps
module qdr4_sram_bench;
  localparam int AW    = 4;
  localparam int DW    = 18;
  localparam int LANES = 2;
  localparam int LW    = DW / LANES;
  localparam int NW    = (1 << AW) * 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_req_n = 1'b1, wr_req_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wd_rise = '0, wd_fall = '0;
  logic [LANES-1:0] wbe_rise_n = '1, wbe_fall_n = '1;
  logic [DW-1:0]    rd_rise, rd_fall;
  logic             rd_oe;

  always #4 clk = ~clk;

  qdr4_sram #(.AW(AW), .DW(DW), .LANES(LANES)) u_qdr4_sram (
    .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
    .addr(addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wbe_rise_n(wbe_rise_n), .wbe_fall_n(wbe_fall_n),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .rd_oe(rd_oe)
  );

  int  n_chk = 0, n_bad = 0, cyc = 0;
  bit  done = 1'b0;

  logic [DW-1:0]   sh [NW];
  logic [2*DW:0]   q_dat [$];
  int              q_due [$];
  string           q_tag [$];

  bit                          p_v = 1'b0;
  logic [AW-1:0]               p_a;
  logic [3:0][DW-1:0]          p_w;
  logic [3:0][LANES-1:0]       p_bn;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int g, int b, int s);
    return DW'(g * 4099 + b * 613 + s * 28657 + 18'h15a5a);
  endfunction

  function automatic logic [3:0][DW-1:0] group_pat(int g, int s);
    logic [3:0][DW-1:0] r;
    for (int b = 0; b < 4; b++) r[b] = pat(g, b, s);
    return r;
  endfunction

  // scoreboard driver side: commit the bench's own pending write
  task automatic apply_pending();
    for (int b = 0; b < 4; b++)
      for (int l = 0; l < LANES; l++)
        if (!p_bn[b][l]) sh[int'(p_a) * 4 + b][l*LW +: LW] = p_w[b][l*LW +: LW];
  endtask

  task automatic push_read(logic [AW-1:0] g, string tag);
    for (int h = 0; h < 2; h++) begin
      q_dat.push_back({1'b1, sh[int'(g) * 4 + 2*h + 1], sh[int'(g) * 4 + 2*h]});
      q_due.push_back(cyc + 2 + h);
      q_tag.push_back(tag);
    end
  endtask

  // one two-cycle slot; called and returning just after a falling edge
  task automatic slot(bit do_rd, logic [AW-1:0] ra, bit do_wr, logic [AW-1:0] wa,
                      logic [3:0][DW-1:0] w, logic [3:0][LANES-1:0] bn,
                      bit noise, string tag);
    logic [1:0][DW-1:0]    cw;
    logic [1:0][LANES-1:0] cb;
    if (p_v) begin
      apply_pending();
      cw[0] = p_w[2]; cw[1] = p_w[3];
      cb[0] = p_bn[2]; cb[1] = p_bn[3];
    end else begin
      cw[0] = 18'h2aaaa; cw[1] = 18'h15555;
      cb = '0;
    end
    if (do_rd) push_read(ra, tag);
    p_v  = do_wr && !do_rd;
    p_a  = wa;
    p_w  = w;
    p_bn = bn;
    rd_req_n = !do_rd; wr_req_n = !do_wr; addr = ra;
    wd_rise = cw[0]; wd_fall = cw[1]; wbe_rise_n = cb[0]; wbe_fall_n = cb[1];
    @(posedge clk); @(negedge clk);
    rd_req_n = !noise; wr_req_n = !noise; addr = wa;
    wd_rise = w[0]; wd_fall = w[1]; wbe_rise_n = bn[0]; wbe_fall_n = bn[1];
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    slot(1'b0, '0, 1'b0, '0, group_pat(0, 99), '1, 1'b0, "idle");
  endtask

  // scoreboard monitor: exact cycle of every word pair (R3, R8)
  always @(negedge clk) begin
    if (!done) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        logic [2*DW:0] e;
        string t;
        e = q_dat.pop_front();
        t = q_tag.pop_front();
        void'(q_due.pop_front());
        check(t, {27'd0, rd_oe, rd_fall, rd_rise}, {27'd0, e});
      end else begin
        check("R8 idle port", {27'd0, rd_oe, rd_fall, rd_rise}, 64'd0);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {27'd0, rd_oe, rd_fall, rd_rise}, 64'd0);
    rst_n = 1'b1;

    // R4 fill every group with full-lane writes
    for (int g = 0; g < (1 << AW); g++)
      slot(1'b0, '0, 1'b1, AW'(g), group_pat(g, 0), '0, 1'b0, "R4 fill");
    idle();

    // R3 R9 back-to-back reads of all groups, R8 continuous enable
    for (int g = 0; g < (1 << AW); g++)
      slot(1'b1, AW'(g), 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R3 R9 read burst");
    idle();

    // R7 read right after write to same group
    slot(1'b0, '0, 1'b1, 4'd5, group_pat(5, 1), '0, 1'b0, "");
    slot(1'b1, 4'd5, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R7 forwarded read");

    // R6 lane masks, forwarded then from the array
    slot(1'b0, '0, 1'b1, 4'd6, group_pat(6, 2), {2'b01, 2'b10, 2'b00, 2'b11}, 1'b0, "");
    slot(1'b1, 4'd6, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R6 R7 masked forward");
    idle();
    slot(1'b1, 4'd6, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R6 masked array read");

    // R5 both strobes: read wins, write dropped
    slot(1'b1, 4'd7, 1'b1, 4'd8, group_pat(8, 3), '0, 1'b0, "R5 read wins");
    idle();
    slot(1'b1, 4'd8, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R5 write dropped");

    // R2 strobes on the second edge of a slot are ignored
    slot(1'b0, 4'd9, 1'b0, 4'd9, group_pat(9, 4), '0, 1'b1, "");
    idle();
    slot(1'b1, 4'd9, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R2 off-slot strobe ignored");

    // read / write / read on one group, partial lanes on the rise beats
    slot(1'b1, 4'd3, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R3 before write");
    slot(1'b0, '0, 1'b1, 4'd3, group_pat(3, 5), {2'b00, 2'b00, 2'b10, 2'b01}, 1'b0, "");
    slot(1'b1, 4'd3, 1'b1, 4'd4, group_pat(4, 6), '0, 1'b0, "R7 R5 forward with dual strobe");
    slot(1'b1, 4'd15, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R9 top group");
    idle();
    idle();

    // R1 reset keeps array contents and restarts slots
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 outputs during reset", {27'd0, rd_oe, rd_fall, rd_rise}, 64'd0);
    rst_n = 1'b1;
    slot(1'b1, 4'd10, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R1 array kept after reset");
    slot(1'b1, 4'd6, 1'b0, '0, group_pat(0, 0), '1, 1'b0, "R1 R6 array kept after reset");
    idle();
    idle();

    check("R3 all read data delivered", 64'(q_due.size()), 64'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule